// File: doc/BRIEF.md
# Dithered Dual-Channel PWM Generator

This block dims two LED strings from one shared phase-correct timer. Each channel receives a 15-bit brightness level. The top eight bits set the base duty of an 8-bit compare. The low seven bits are a dither fraction. A first-order error accumulator turns that fraction into an occasional one-count bump of the compare value, applied one timer period at a time. Averaged over many periods, each output therefore resolves brightness to 15 bits, although the timer itself counts only to 255.

A level pair arrives as one beat on a valid/ready stream. The block never applies back-pressure: `lvl_ready` is always high, so every cycle with `lvl_valid` high transfers one beat and no beat waits. The new base duty reaches the compare register in the cycle after the transfer, without waiting for the next period boundary. A plain `off_req` control pin forces both channels dark. `tick_en` is a clock enable that advances the shared counter.

Top module: `pwmd_dual`

## Requirements
- R1: After reset, both compare values are 0 and both PWM outputs are low.
- R2: The shared counter starts at 0 and moves by one on each cycle that has `tick_en` high. It runs up to 255, turns, runs down to 0, and repeats, so one period is 510 enabled cycles. It holds its value while `tick_en` is low. A period boundary is an enabled cycle in which the counter is at 0.
- R3: A PWM output is high when its compare value is 255, or when the counter is below the compare value. Otherwise it is low. A compare value of 0 therefore keeps the output low all the time.
- R4: When a beat transfers, each channel's compare value and pending value both become that channel's level bits [14:7] in the next cycle. Levels never exceed 0x7F80, which is 255 shifted left by 7.
- R5: At a period boundary with no load and no off request, the compare value takes the pending value. In any cycle with no boundary, no load and no off request, the compare value holds.
- R6: At that same boundary, sum = accumulator + level bits [6:0]. The new pending value is level bits [14:7] plus bit 7 of sum, and the accumulator keeps sum bits [6:0].
- R7: Reset clears both accumulators. A level load or an off request leaves the accumulators unchanged, so the dither phase carries over from one level to the next.
- R8: `off_req` clears both levels, both compare values and both pending values in the next cycle. Both outputs then stay low until a new level is loaded.
- R9: Priority is off request, then load, then boundary update. A boundary that coincides with a load or an off request performs no accumulator update.
- R10: `lvl_ready` is always high.
- R11: Over any 128 consecutive boundary updates at a fixed level with fraction f, exactly f of the resulting compare values are base+1 and the rest are base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter advance enable |
| off_req | input | 1 | Force both channels dark |
| lvl_valid | input | 1 | Level beat valid |
| lvl_ready | output | 1 | Level beat ready (always 1) |
| lvl_a | input | 15 | Channel A level: duty [14:7], fraction [6:0] |
| lvl_b | input | 15 | Channel B level: duty [14:7], fraction [6:0] |
| pwm_a | output | 1 | Channel A PWM output |
| pwm_b | output | 1 | Channel B PWM output |
| cmp_a | output | 8 | Channel A active compare value |
| cmp_b | output | 8 | Channel B active compare value |

## Verification
The checker assumes that every transferred level is at most 0x7F80. This keeps the base-plus-carry sum within eight bits. The random stimulus draws levels only up to that bound, and the directed cases sit exactly on it.

The checker also assumes that the inputs change only between clock edges. The bench therefore drives them on the falling edge. Load beats and off requests are sparse and random, and some are forced to coincide with each other and with period boundaries. This exercises the priority rule without violating these assumptions.

// File: rtl/pwmd_pkg.sv
package pwmd_pkg;
  typedef enum logic {CNT_UP = 1'b0, CNT_DOWN = 1'b1} cnt_dir_e;

  localparam int DEF_DUTY_W = 8;
  localparam int DEF_FRAC_W = 7;
endpackage

// File: rtl/pwmd_updown_cnt.sv
module pwmd_updown_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  import pwmd_pkg::*;

  localparam logic [W-1:0] TOP = '1;
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  cnt_dir_e     dir_q;
  logic [W-1:0] cnt_q;

  assign cnt_o  = cnt_q;
  assign wrap_o = adv_i && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= CNT_UP;
    end else if (adv_i) begin
      if (dir_q == CNT_UP) begin
        cnt_q <= cnt_q + ONE;
        if (cnt_q + ONE == TOP) dir_q <= CNT_DOWN;
      end else begin
        cnt_q <= cnt_q - ONE;
        if (cnt_q - ONE == '0) dir_q <= CNT_UP;
      end
    end
  end
endmodule

// File: rtl/pwmd_dither_chan.sv
module pwmd_dither_chan #(
  parameter int DUTY_W = 8,
  parameter int FRAC_W = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       off_i,
  input  logic                       load_i,
  input  logic [DUTY_W+FRAC_W-1:0]   level_i,
  input  logic                       wrap_i,
  output logic [DUTY_W-1:0]          cmp_o
);
  localparam int LVL_W = DUTY_W + FRAC_W;

  logic [LVL_W-1:0]  level_q;
  logic [DUTY_W-1:0] cmp_q;
  logic [DUTY_W-1:0] nxt_q;
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;
  logic [DUTY_W-1:0] carry_ext;

  assign sum       = {1'b0, acc_q} + {1'b0, level_q[FRAC_W-1:0]};
  assign carry_ext = {{(DUTY_W-1){1'b0}}, sum[FRAC_W]};
  assign cmp_o     = cmp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_q <= '0;
      cmp_q   <= '0;
      nxt_q   <= '0;
      acc_q   <= '0;
    end else if (off_i) begin
      level_q <= '0;
      cmp_q   <= '0;
      nxt_q   <= '0;
    end else if (load_i) begin
      level_q <= level_i;
      cmp_q   <= level_i[LVL_W-1:FRAC_W];
      nxt_q   <= level_i[LVL_W-1:FRAC_W];
    end else if (wrap_i) begin
      cmp_q   <= nxt_q;
      nxt_q   <= level_q[LVL_W-1:FRAC_W] + carry_ext;
      acc_q   <= sum[FRAC_W-1:0];
    end
  end
endmodule

// File: rtl/pwmd_compare.sv
module pwmd_compare #(
  parameter int W = 8
) (
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] cmp_i,
  output logic         out_o
);
  localparam logic [W-1:0] TOP = '1;

  always_comb out_o = (cmp_i == TOP) || (cnt_i < cmp_i);
endmodule

// File: rtl/pwmd_dual.sv
module pwmd_dual #(
  parameter int DUTY_W = pwmd_pkg::DEF_DUTY_W,
  parameter int FRAC_W = pwmd_pkg::DEF_FRAC_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick_en,
  input  logic                     off_req,
  input  logic                     lvl_valid,
  output logic                     lvl_ready,
  input  logic [DUTY_W+FRAC_W-1:0] lvl_a,
  input  logic [DUTY_W+FRAC_W-1:0] lvl_b,
  output logic                     pwm_a,
  output logic                     pwm_b,
  output logic [DUTY_W-1:0]        cmp_a,
  output logic [DUTY_W-1:0]        cmp_b
);
  localparam int LVL_W = DUTY_W + FRAC_W;
  localparam int NCH   = 2;

  logic [DUTY_W-1:0] cnt_q;
  logic              wrap;
  logic              load;
  logic [LVL_W-1:0]  lvl_in  [NCH];
  logic [DUTY_W-1:0] cmp_arr [NCH];
  logic              pwm_arr [NCH];

  assign lvl_ready = 1'b1;
  assign load      = lvl_valid && lvl_ready;
  assign lvl_in[0] = lvl_a;
  assign lvl_in[1] = lvl_b;

  pwmd_updown_cnt #(.W(DUTY_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv_i  (tick_en),
    .cnt_o  (cnt_q),
    .wrap_o (wrap)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwmd_dither_chan #(.DUTY_W(DUTY_W), .FRAC_W(FRAC_W)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .off_i   (off_req),
      .load_i  (load),
      .level_i (lvl_in[g]),
      .wrap_i  (wrap),
      .cmp_o   (cmp_arr[g])
    );

    pwmd_compare #(.W(DUTY_W)) u_cmp (
      .cnt_i (cnt_q),
      .cmp_i (cmp_arr[g]),
      .out_o (pwm_arr[g])
    );
  end

  assign cmp_a = cmp_arr[0];
  assign cmp_b = cmp_arr[1];
  assign pwm_a = pwm_arr[0];
  assign pwm_b = pwm_arr[1];
endmodule

// File: rtl/pwmd_dual_chk.sv
module pwmd_dual_chk #(
  parameter int DUTY_W = 8,
  parameter int FRAC_W = 7
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     tick_en,
  input logic                     off_req,
  input logic                     lvl_valid,
  input logic                     lvl_ready,
  input logic [DUTY_W+FRAC_W-1:0] lvl_a,
  input logic [DUTY_W+FRAC_W-1:0] lvl_b,
  input logic                     pwm_a,
  input logic                     pwm_b,
  input logic [DUTY_W-1:0]        cmp_a,
  input logic [DUTY_W-1:0]        cmp_b,
  input logic [DUTY_W-1:0]        cnt,
  input logic                     wrap
);
  localparam int LVL_W = DUTY_W + FRAC_W;
  localparam logic [DUTY_W-1:0] TOP = '1;
  localparam logic [LVL_W-1:0] MAX_LVL = {TOP, {FRAC_W{1'b0}}};
  localparam logic [DUTY_W-1:0] ONE = {{(DUTY_W-1){1'b0}}, 1'b1};

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(cnt));

  // R2
  cnt_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt == ONE);

  // R3
  dark_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmp_a == '0) |-> !pwm_a) and ((cmp_b == '0) |-> !pwm_b));

  // R3
  lit_at_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmp_a == TOP) |-> pwm_a) and ((cmp_b == TOP) |-> pwm_b));

  // R4
  level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_valid |-> (lvl_a <= MAX_LVL) && (lvl_b <= MAX_LVL));

  // R4
  load_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_valid && !off_req) |=>
      (cmp_a == $past(lvl_a[LVL_W-1:FRAC_W])) && (cmp_b == $past(lvl_b[LVL_W-1:FRAC_W])));

  // R5
  cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!off_req && !lvl_valid && !wrap) |=> $stable(cmp_a) && $stable(cmp_b));

  // R8
  off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    off_req |=> (cmp_a == '0) && (cmp_b == '0) && !pwm_a && !pwm_b);

  // R10
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_ready);
endmodule

bind pwmd_dual pwmd_dual_chk #(.DUTY_W(DUTY_W), .FRAC_W(FRAC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_en   (tick_en),
  .off_req   (off_req),
  .lvl_valid (lvl_valid),
  .lvl_ready (lvl_ready),
  .lvl_a     (lvl_a),
  .lvl_b     (lvl_b),
  .pwm_a     (pwm_a),
  .pwm_b     (pwm_b),
  .cmp_a     (cmp_a),
  .cmp_b     (cmp_b),
  .cnt       (cnt_q),
  .wrap      (wrap)
);

// File: tb/pwmd_dual_test.sv
module pwmd_dual_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        off_req = 1'b0;
  logic        lvl_valid = 1'b0;
  logic        lvl_ready;
  logic [14:0] lvl_a = '0;
  logic [14:0] lvl_b = '0;
  logic        pwm_a, pwm_b;
  logic [7:0]  cmp_a, cmp_b;

  int total = 0;
  int bad = 0;

  // bench model state
  int m_cnt = 0;
  bit m_up = 1'b1;
  int m_lvl [2] = '{0, 0};
  int m_cmp [2] = '{0, 0};
  int m_nxt [2] = '{0, 0};
  int m_acc [2] = '{0, 0};
  bit m_wrap = 1'b0;
  string cause = "R1";

  always #2.5 clk = ~clk;

  pwmd_dual uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .off_req(off_req),
    .lvl_valid(lvl_valid), .lvl_ready(lvl_ready), .lvl_a(lvl_a), .lvl_b(lvl_b),
    .pwm_a(pwm_a), .pwm_b(pwm_b), .cmp_a(cmp_a), .cmp_b(cmp_b)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_pwm(int cmpv, int cntv);
    return (cmpv == 255) || (cntv < cmpv);
  endfunction

  task automatic model_step(bit tk, bit off, bit vld, int la, int lb);
    int lv [2];
    lv[0] = la; lv[1] = lb;
    m_wrap = tk && (m_cnt == 0);
    if (off && (vld || m_wrap)) cause = "R9";
    else if (off) cause = "R8";
    else if (vld && m_wrap) cause = "R9";
    else if (vld) cause = "R4";
    else if (m_wrap) cause = "R6";
    else cause = "R5";
    for (int c = 0; c < 2; c++) begin
      if (off) begin
        m_lvl[c] = 0; m_cmp[c] = 0; m_nxt[c] = 0;
      end else if (vld) begin
        m_lvl[c] = lv[c]; m_cmp[c] = lv[c] >> 7; m_nxt[c] = lv[c] >> 7;
      end else if (m_wrap) begin
        int s;
        s = m_acc[c] + (m_lvl[c] & 127);
        m_cmp[c] = m_nxt[c];
        m_nxt[c] = (m_lvl[c] >> 7) + (s > 127 ? 1 : 0);
        m_acc[c] = s & 127;
      end
    end
    if (tk) begin
      if (m_up) begin
        m_cnt++;
        if (m_cnt == 255) m_up = 1'b0;
      end else begin
        m_cnt--;
        if (m_cnt == 0) m_up = 1'b1;
      end
    end
  endtask

  // called at a falling edge: drive, model, wait one cycle, compare
  task automatic cyc(bit tk, bit off, bit vld, int la, int lb);
    tick_en = tk; off_req = off; lvl_valid = vld;
    lvl_a = 15'(la); lvl_b = 15'(lb);
    model_step(tk, off, vld, la, lb);
    @(negedge clk);
    check({cause, " cmp_a"}, int'(cmp_a), m_cmp[0]);
    check({cause, " cmp_b"}, int'(cmp_b), m_cmp[1]);
    check("R2 R3 pwm_a", int'(pwm_a), int'(exp_pwm(m_cmp[0], m_cnt)));
    check("R2 R3 pwm_b", int'(pwm_b), int'(exp_pwm(m_cmp[1], m_cnt)));
    check("R10 ready", int'(lvl_ready), 1);
  endtask

  task automatic idle_to_wrap();
    do cyc(1'b1, 1'b0, 1'b0, 0, 0); while (!m_wrap);
  endtask

  initial begin
    int hits_a, hits_b;
    void'($urandom(32'h5eed1234));
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 cmp_a", int'(cmp_a), 0);
    check("R1 cmp_b", int'(cmp_b), 0);
    check("R1 pwm_a", int'(pwm_a), 0);
    check("R1 pwm_b", int'(pwm_b), 0);
    rst_n = 1'b1;

    // directed: full-on and off at boundary values (R3, R4)
    cyc(1'b1, 1'b0, 1'b1, 32'h7F80, 0);
    repeat (600) cyc(1'b1, 1'b0, 1'b0, 0, 0);
    // coincident load and off (R9)
    cyc(1'b1, 1'b1, 1'b1, 32'h4000, 32'h4000);
    check("R8 cmp_a after off", int'(cmp_a), 0);
    repeat (520) cyc(1'b1, 1'b0, 1'b0, 0, 0);

    // R7: accumulator kept across a load
    idle_to_wrap();
    cyc(1'b1, 1'b0, 1'b1, (20 << 7) | 100, (20 << 7) | 100);
    idle_to_wrap();   // pending = 20, acc 100
    idle_to_wrap();   // cmp = 20, acc stays 100 after one more add? check below
    cyc(1'b1, 1'b0, 1'b1, (30 << 7) | 40, (30 << 7) | 40);
    idle_to_wrap();
    idle_to_wrap();
    check("R7 carry kept", int'(cmp_a), m_cmp[0]);
    check("R7 base", (m_cmp[0] == 30 || m_cmp[0] == 31) ? 1 : 0, 1);

    // random phase
    for (int i = 0; i < 30000; i++) begin
      bit tk, off, vld;
      tk  = ($urandom % 10) != 0;
      off = ($urandom % 2500) == 0;
      vld = ($urandom % 400) == 0;
      cyc(tk, off, vld, $urandom % 32641, $urandom % 32641);
    end

    // R11: dither density over 128 boundary updates
    idle_to_wrap();
    cyc(1'b1, 1'b0, 1'b1, (10 << 7) | 37, (3 << 7) | 127);
    idle_to_wrap();
    hits_a = 0; hits_b = 0;
    for (int p = 0; p < 128; p++) begin
      idle_to_wrap();
      if (cmp_a == 8'd11) hits_a++;
      if (cmp_b == 8'd4) hits_b++;
    end
    check("R11 density a", hits_a, 37);
    check("R11 density b", hits_b, 127);

    // R2: counter frozen, outputs stable
    repeat (50) cyc(1'b0, 1'b0, 1'b0, 0, 0);
    // R8: off keeps both dark across boundaries
    cyc(1'b1, 1'b1, 1'b0, 0, 0);
    repeat (1100) cyc(1'b1, 1'b0, 1'b0, 0, 0);
    check("R8 pwm_a dark", int'(pwm_a), 0);
    check("R8 pwm_b dark", int'(pwm_b), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule